// File: doc/BRIEF.md
# Two-Step Transmit Timestamp Queue

This block gathers egress timestamps for frames that need a follow-up message carrying their exact send time. A shared stamping point presents one request per stamped frame: the egress port, the nanosecond time at which the frame left, and the frame's sequence identifier. For every accepted request the queue stores two consecutive entries. The first is the transmit entry, which carries the transmit flag, the port and the nanosecond time. The second is the identifier entry, which has its transmit flag clear and carries the identifier split across the stamp word (upper bits) and the sub-nanosecond byte (low eight bits). Software rebuilds the identifier as (stamp << 8) | sub-nanosecond byte.

The reader sees the head entry through a status group (valid, sticky overflow, transmit flag, port) and a stamp group (nanosecond word and sub-nanosecond byte). A one-cycle "next" pulse pops exactly one entry, so a full event takes two pops. A request is taken only if two free slots exist. Otherwise the pair is dropped as a whole and the overflow flag is set until it is cleared with a one-cycle clear pulse.

The push side is a two-state machine. PUSH_IDLE accepts a request, writes the transmit entry and moves to PUSH_ID. On a full queue it stays in PUSH_IDLE and raises overflow. PUSH_ID writes the identifier entry and always returns to PUSH_IDLE. The ready output is high only in PUSH_IDLE.

Top module: `tsq_twostep_fifo`

## Requirements
- R1: After reset the valid flag and the overflow flag are 0 and push_ready is 1.
- R2: An accepted request stores two entries in order. First is a transmit entry: tx flag 1, the request's port, stamp = the request's nanosecond time. Second is an identifier entry: tx flag 0, the same port, stamp = identifier bits above bit 7 (zero-extended), sub-nanosecond byte = identifier bits 7..0.
- R3: The valid flag is 1 exactly when a head entry is present. The transmit entry is visible in the cycle after acceptance, and the identifier entry is written one cycle later.
- R4: A pop pulse removes exactly one head entry. A pop on an empty queue has no effect.
- R5: Entries leave in arrival order, whatever their ports.
- R6: A request that arrives with fewer than two free slots stores neither entry and sets overflow. A request with exactly two free slots is accepted.
- R7: Overflow stays set until a clear pulse. If a drop and a clear fall in the same cycle, overflow ends up set.
- R8: push_ready is 0 in the cycle in which the identifier entry is written. A request offered in that cycle is ignored.
- R9: Identifiers span 0 to 511. Identifier 511 reads back as stamp 1 and byte 255, and identifier 256 reads back as stamp 1 and byte 0.
- R10: A pop and an accepted request in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Stamp request present |
| push_port | input | PORT_W | Egress port of the stamped frame |
| push_nsec | input | NSEC_W | Nanosecond transmit time |
| push_id | input | ID_W | Frame sequence identifier |
| push_ready | output | 1 | Request can be taken this cycle |
| pop_next | input | 1 | One-cycle pulse: discard head entry |
| ovfl_clr | input | 1 | One-cycle pulse: clear overflow |
| st_valid | output | 1 | Head entry present |
| st_ovfl | output | 1 | Sticky: a pair was dropped |
| st_tx | output | 1 | Head entry is a transmit entry |
| st_port | output | PORT_W | Port of head entry |
| stamp_nsec | output | NSEC_W | Stamp word of head entry |
| stamp_subns | output | 8 | Sub-nanosecond byte of head entry |

## Verification
A table of four requests from different ports, with extreme times and the identifiers 0, 5, 256 and 511, fills the queue exactly. Draining it shows that pairing, ordering and the identifier split are right, and that six occupied slots still admit a request. Directed cases push at a full queue and at seven occupied slots, which tells the two-free-slot rule apart from a one-slot check. They also pop on an empty queue, offer a request while the identifier entry is being written, and pop during an acceptance. Separate cases apply the overflow clear alone and together with a drop, which shows which of the two wins.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    localparam int unsigned SUB_W = 8;

    typedef enum logic [0:0] {
        PUSH_IDLE = 1'b0,
        PUSH_ID   = 1'b1
    } push_state_e;
endpackage

// File: rtl/tsq_push_fsm.sv
module tsq_push_fsm
    import tsq_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PORT_W = 7,
    parameter int unsigned NSEC_W = 30,
    parameter int unsigned ID_W   = 9,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [PORT_W-1:0] push_port,
    input  logic [NSEC_W-1:0] push_nsec,
    input  logic [ID_W-1:0]   push_id,
    input  logic [CNT_W-1:0]  fill,
    input  logic              ovfl_clr,
    output logic              wr_en,
    output logic              wr_tx,
    output logic [PORT_W-1:0] wr_port,
    output logic [NSEC_W-1:0] wr_nsec,
    output logic [SUB_W-1:0]  wr_sub,
    output logic              push_ready,
    output logic              ovfl
);
    localparam int unsigned    ID_HI_W     = ID_W - SUB_W;
    localparam logic [CNT_W-1:0] PAIR_LIMIT = CNT_W'(DEPTH - 2);

    push_state_e       state_q, state_d;
    logic [PORT_W-1:0] port_q;
    logic [ID_W-1:0]   id_q;
    logic              take, drop;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PUSH_IDLE;
        else        state_q <= state_d;
    end

    // request capture and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            id_q   <= '0;
            ovfl   <= 1'b0;
        end else begin
            if (take) begin
                port_q <= push_port;
                id_q   <= push_id;
            end
            if (drop)          ovfl <= 1'b1;
            else if (ovfl_clr) ovfl <= 1'b0;
        end
    end

    // outputs and next state
    always_comb begin
        state_d    = state_q;
        wr_en      = 1'b0;
        wr_tx      = 1'b0;
        wr_port    = '0;
        wr_nsec    = '0;
        wr_sub     = '0;
        push_ready = 1'b0;
        take       = 1'b0;
        drop       = 1'b0;
        unique case (state_q)
            PUSH_IDLE: begin
                push_ready = 1'b1;
                if (push_valid) begin
                    if (fill <= PAIR_LIMIT) begin
                        take    = 1'b1;
                        wr_en   = 1'b1;
                        wr_tx   = 1'b1;
                        wr_port = push_port;
                        wr_nsec = push_nsec;
                        state_d = PUSH_ID;
                    end else begin
                        drop = 1'b1;
                    end
                end
            end
            PUSH_ID: begin
                wr_en   = 1'b1;
                wr_tx   = 1'b0;
                wr_port = port_q;
                wr_nsec = {{(NSEC_W - ID_HI_W){1'b0}}, id_q[ID_W-1:SUB_W]};
                wr_sub  = id_q[SUB_W-1:0];
                state_d = PUSH_IDLE;
            end
            default: state_d = PUSH_IDLE;
        endcase
    end

    AST_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tx) |=> (wr_en && !wr_tx)); // R2
    AST_OVFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovfl && !ovfl_clr) |=> ovfl); // R7
    AST_DROP_SETS_OVFL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ready && push_valid && fill > PAIR_LIMIT) |=> ovfl); // R6
    AST_BUSY_WHILE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_tx) |-> !push_ready); // R8
endmodule

// File: rtl/tsq_store.sv
module tsq_store
    import tsq_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PORT_W = 7,
    parameter int unsigned NSEC_W = 30,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_tx,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [NSEC_W-1:0] wr_nsec,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic              pop,
    output logic [CNT_W-1:0]  fill,
    output logic              head_valid,
    output logic              head_tx,
    output logic [PORT_W-1:0] head_port,
    output logic [NSEC_W-1:0] head_nsec,
    output logic [SUB_W-1:0]  head_sub
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic              tx_mem   [DEPTH];
    logic [PORT_W-1:0] port_mem [DEPTH];
    logic [NSEC_W-1:0] nsec_mem [DEPTH];
    logic [SUB_W-1:0]  sub_mem  [DEPTH];

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop;

    assign head_valid = (fill != '0);
    assign do_pop     = pop && head_valid;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tx_mem[wr_ptr]   <= wr_tx;
            port_mem[wr_ptr] <= wr_port;
            nsec_mem[wr_ptr] <= wr_nsec;
            sub_mem[wr_ptr]  <= wr_sub;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en)  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({wr_en, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head_tx   = tx_mem[rd_ptr];
    assign head_port = port_mem[rd_ptr];
    assign head_nsec = nsec_mem[rd_ptr];
    assign head_sub  = sub_mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fill < CNT_W'(DEPTH) || do_pop)); // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && !wr_en) |=> (fill == '0)); // R4
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !wr_en && fill != '0) |=> (fill == $past(fill) - 1'b1)); // R4
endmodule

// File: rtl/tsq_twostep_fifo.sv
module tsq_twostep_fifo
    import tsq_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PORTS  = 65,
    parameter int unsigned NSEC_W = 30,
    parameter int unsigned ID_W   = 9,
    localparam int unsigned PORT_W = $clog2(PORTS),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [PORT_W-1:0] push_port,
    input  logic [NSEC_W-1:0] push_nsec,
    input  logic [ID_W-1:0]   push_id,
    output logic              push_ready,
    input  logic              pop_next,
    input  logic              ovfl_clr,
    output logic              st_valid,
    output logic              st_ovfl,
    output logic              st_tx,
    output logic [PORT_W-1:0] st_port,
    output logic [NSEC_W-1:0] stamp_nsec,
    output logic [7:0]        stamp_subns
);
    if ((DEPTH % 2) != 0 || DEPTH < 2) begin : g_bad_depth
        $error("tsq_twostep_fifo: DEPTH must be even and at least 2");
    end
    if (ID_W <= SUB_W || ID_W - SUB_W > NSEC_W) begin : g_bad_id
        $error("tsq_twostep_fifo: ID_W out of range");
    end

    logic              wr_en, wr_tx;
    logic [PORT_W-1:0] wr_port;
    logic [NSEC_W-1:0] wr_nsec;
    logic [SUB_W-1:0]  wr_sub;
    logic [CNT_W-1:0]  fill;

    tsq_push_fsm #(
        .DEPTH (DEPTH),
        .PORT_W(PORT_W),
        .NSEC_W(NSEC_W),
        .ID_W  (ID_W)
    ) i_push (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(push_valid),
        .push_port (push_port),
        .push_nsec (push_nsec),
        .push_id   (push_id),
        .fill      (fill),
        .ovfl_clr  (ovfl_clr),
        .wr_en     (wr_en),
        .wr_tx     (wr_tx),
        .wr_port   (wr_port),
        .wr_nsec   (wr_nsec),
        .wr_sub    (wr_sub),
        .push_ready(push_ready),
        .ovfl      (st_ovfl)
    );

    tsq_store #(
        .DEPTH (DEPTH),
        .PORT_W(PORT_W),
        .NSEC_W(NSEC_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_tx     (wr_tx),
        .wr_port   (wr_port),
        .wr_nsec   (wr_nsec),
        .wr_sub    (wr_sub),
        .pop       (pop_next),
        .fill      (fill),
        .head_valid(st_valid),
        .head_tx   (st_tx),
        .head_port (st_port),
        .head_nsec (stamp_nsec),
        .head_sub  (stamp_subns)
    );
endmodule

// File: tb/test_tsq_twostep_fifo.sv
`timescale 1ns/1ps
module test_tsq_twostep_fifo;
    localparam int PORT_W = 7;
    localparam int NSEC_W = 30;
    localparam int ID_W   = 9;
    localparam int VW     = PORT_W + NSEC_W + ID_W;
    localparam int NV     = 4;

    // {port, nsec, id}
    localparam logic [VW-1:0] VEC [NV] = '{
        {7'd3,  30'd123456789, 9'd5},
        {7'd64, 30'd999999999, 9'd511},
        {7'd0,  30'd0,         9'd256},
        {7'd17, 30'd42,        9'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [PORT_W-1:0] push_port = '0;
    logic [NSEC_W-1:0] push_nsec = '0;
    logic [ID_W-1:0]   push_id = '0;
    logic push_ready, pop_next = 1'b0, ovfl_clr = 1'b0;
    logic st_valid, st_ovfl, st_tx;
    logic [PORT_W-1:0] st_port;
    logic [NSEC_W-1:0] stamp_nsec;
    logic [7:0] stamp_subns;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tsq_twostep_fifo i_tsq_twostep_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_port(push_port),
        .push_nsec(push_nsec), .push_id(push_id), .push_ready(push_ready),
        .pop_next(pop_next), .ovfl_clr(ovfl_clr),
        .st_valid(st_valid), .st_ovfl(st_ovfl), .st_tx(st_tx),
        .st_port(st_port), .stamp_nsec(stamp_nsec), .stamp_subns(stamp_subns)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [PORT_W-1:0] p, input logic [NSEC_W-1:0] n,
                        input logic [ID_W-1:0] id);
        push_valid = 1'b1; push_port = p; push_nsec = n; push_id = id;
        tick();
        push_valid = 1'b0;
        tick();
    endtask

    task automatic pop1();
        pop_next = 1'b1;
        tick();
        pop_next = 1'b0;
    endtask

    task automatic check_tx(input logic [PORT_W-1:0] p, input logic [NSEC_W-1:0] n, input string tag);
        chk(st_valid == 1'b1, {tag, " valid"}, st_valid, 1);
        chk(st_tx == 1'b1, {tag, " tx"}, st_tx, 1);
        chk(st_port == p, {tag, " port"}, st_port, p);
        chk(stamp_nsec == n, {tag, " nsec"}, stamp_nsec, n);
    endtask

    task automatic check_id(input logic [PORT_W-1:0] p, input logic [ID_W-1:0] id, input string tag);
        chk(st_valid == 1'b1, {tag, " valid"}, st_valid, 1);
        chk(st_tx == 1'b0, {tag, " tx"}, st_tx, 0);
        chk(st_port == p, {tag, " port"}, st_port, p);
        chk(stamp_nsec == NSEC_W'(id >> 8), {tag, " id hi"}, stamp_nsec, id >> 8);
        chk(stamp_subns == id[7:0], {tag, " id lo"}, stamp_subns, id[7:0]);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        chk(st_valid == 1'b0, "R1 valid", st_valid, 0);
        chk(st_ovfl == 1'b0, "R1 ovfl", st_ovfl, 0);
        chk(push_ready == 1'b1, "R1 ready", push_ready, 1);
        rst_n = 1'b1;
        tick();

        // R3 / R8 timing of the first pair
        push_valid = 1'b1;
        push_port = VEC[0][VW-1 -: PORT_W];
        push_nsec = VEC[0][ID_W +: NSEC_W];
        push_id = VEC[0][ID_W-1:0];
        tick();
        push_valid = 1'b0;
        chk(st_valid == 1'b1, "R3 tx entry visible", st_valid, 1);
        chk(push_ready == 1'b0, "R8 ready low in id write", push_ready, 0);
        tick();
        chk(push_ready == 1'b1, "R8 ready back", push_ready, 1);

        // table: remaining pushes fill the queue exactly (R6 six occupied accepted)
        for (int i = 1; i < NV; i++)
            push(VEC[i][VW-1 -: PORT_W], VEC[i][ID_W +: NSEC_W], VEC[i][ID_W-1:0]);
        chk(st_ovfl == 1'b0, "R6 accept with two free", st_ovfl, 0);

        // full: dropped pair
        push(7'd5, 30'd7, 9'd9);
        chk(st_ovfl == 1'b1, "R6 drop sets ovfl", st_ovfl, 1);

        // drain in order: R2 R5 R9
        for (int i = 0; i < NV; i++) begin
            check_tx(VEC[i][VW-1 -: PORT_W], VEC[i][ID_W +: NSEC_W], "R2 R5 tx");
            pop1();
            check_id(VEC[i][VW-1 -: PORT_W], VEC[i][ID_W-1:0], "R2 R9 id");
            pop1();
        end
        chk(st_valid == 1'b0, "R6 dropped pair absent", st_valid, 0);

        // R4 pop on empty
        pop1();
        chk(st_valid == 1'b0, "R4 empty pop", st_valid, 0);
        chk(st_ovfl == 1'b1, "R7 sticky", st_ovfl, 1);
        ovfl_clr = 1'b1; tick(); ovfl_clr = 1'b0;
        chk(st_ovfl == 1'b0, "R7 clear", st_ovfl, 0);
        push(7'd9, 30'd1000, 9'd300);
        check_tx(7'd9, 30'd1000, "R4 after empty pop");
        pop1();
        check_id(7'd9, 9'd300, "R4 after empty pop");
        pop1();
        chk(st_valid == 1'b0, "R4 one per pop", st_valid, 0);

        // R8 request offered during id write is ignored
        push_valid = 1'b1; push_port = 7'd11; push_nsec = 30'd55; push_id = 9'd77;
        tick();
        push_port = 7'd12; push_nsec = 30'd66; push_id = 9'd88;
        tick();
        push_valid = 1'b0;
        tick();
        check_tx(7'd11, 30'd55, "R8 first kept");
        pop1();
        check_id(7'd11, 9'd77, "R8 first kept");
        pop1();
        chk(st_valid == 1'b0, "R8 busy request ignored", st_valid, 0);

        // R10 pop together with acceptance
        push(7'd20, 30'd500, 9'd1);
        push_valid = 1'b1; push_port = 7'd21; push_nsec = 30'd600; push_id = 9'd2;
        pop_next = 1'b1;
        tick();
        push_valid = 1'b0; pop_next = 1'b0;
        tick();
        check_id(7'd20, 9'd1, "R10 head after pop");
        pop1();
        check_tx(7'd21, 30'd600, "R10 pushed tx");
        pop1();
        check_id(7'd21, 9'd2, "R10 pushed id");
        pop1();
        chk(st_valid == 1'b0, "R10 empty", st_valid, 0);

        // R6 seven occupied rejects, R7 drop beats clear
        for (int i = 0; i < NV; i++)
            push(VEC[i][VW-1 -: PORT_W], VEC[i][ID_W +: NSEC_W], VEC[i][ID_W-1:0]);
        pop1();
        push_valid = 1'b1; push_port = 7'd33; push_nsec = 30'd3; push_id = 9'd3;
        ovfl_clr = 1'b1;
        tick();
        push_valid = 1'b0; ovfl_clr = 1'b0;
        tick();
        chk(st_ovfl == 1'b1, "R7 drop wins over clear", st_ovfl, 1);
        check_id(VEC[0][VW-1 -: PORT_W], VEC[0][ID_W-1:0], "R6 seven occupied");
        pop1();
        for (int i = 1; i < NV; i++) begin
            check_tx(VEC[i][VW-1 -: PORT_W], VEC[i][ID_W +: NSEC_W], "R6 R5 tx");
            pop1();
            check_id(VEC[i][VW-1 -: PORT_W], VEC[i][ID_W-1:0], "R6 R5 id");
            pop1();
        end
        chk(st_valid == 1'b0, "R6 one-slot drop not stored", st_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule